// File: doc/BRIEF.md
# Counted Loop Branch Controller

This block resolves the closing branch of a software-pipelined counted loop. It keeps a loop counter, an epilog counter and a rotation base for a rotating predicate window. On every accepted branch request it moves the loop one stage forward. It decides whether the branch is taken. It also produces the stage-valid bit that is written into the top of the rotating predicate window, which is logical predicate 63. One request updates all of this together, so the prolog, kernel and epilog of the pipelined loop run with no extra housekeeping instructions.

A small state machine tracks which of four update cases applies next. The cases are kernel (loop count nonzero), drain (loop count zero, epilog count above one), last (loop count zero, epilog count exactly one) and done (both counts zero). The state is recomputed from the next count values each time a counter changes. Software preloads both counters through a load port. The branch comes in two flavours: a loop-top form and a loop-exit form whose sense is inverted. A separate combinational rename port maps a logical predicate number to its physical slot under the current rotation base.

Top module: `lcb_loop_branch`

## Requirements
- R1: After reset, loop count, epilog count and rotation base are 0, the phase output is done, and no branch is taken.
- R2: An accepted request with a nonzero loop count decrements the loop count, keeps the epilog count, writes stage bit 1 and decrements the rotation base.
- R3: An accepted request with loop count 0 and epilog count above 1 keeps the loop count, decrements the epilog count, writes stage bit 0 and decrements the rotation base.
- R4: An accepted request with loop count 0 and epilog count 1 behaves as in R3 and leaves both counts at 0, so the phase becomes done.
- R5: An accepted request with both counts at 0 changes neither count nor the rotation base, and it writes stage bit 0.
- R6: When br_kind is 0 (loop-top form), the branch is taken only in the kernel and drain cases. When br_kind is 1 (loop-exit form), the branch is taken only in the last and done cases. br_taken is 0 whenever no request is accepted.
- R7: The rotation base steps downward modulo 48, wrapping from 0 to 47.
- R8: For logical predicate numbers 16 to 63, the physical slot is 16 + ((logical - 16 + base) mod 48). Numbers below 16 map to themselves.
- R9: cnt_load loads both counters in the same cycle. A branch request made in that cycle is ignored: no taken, no stage write, and the rotation base is unchanged.
- R10: With no request and no load, the counts and the rotation base hold.
- R11: The phase output is encoded as done=0, kernel=1, drain=2, last=3, and it always reflects the current counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_load | input | 1 | Load both counters from load_lc and load_ec |
| load_lc | input | CNT_W | Loop count value to load |
| load_ec | input | CNT_W | Epilog count value to load |
| br_req | input | 1 | Loop branch request |
| br_kind | input | 1 | 0 = loop-top form, 1 = loop-exit form |
| br_taken | output | 1 | Branch decision for the accepted request |
| stage_pred_we | output | 1 | Write strobe for the stage bit into logical predicate 63 |
| stage_pred_val | output | 1 | Stage bit value |
| loop_cnt | output | CNT_W | Current loop count |
| epi_cnt | output | CNT_W | Current epilog count |
| rot_base | output | BASE_W | Current rotation base |
| loop_phase | output | 2 | Current update case |
| log_pidx | input | IDX_W | Logical predicate number to rename |
| phys_pidx | output | IDX_W | Physical predicate slot |

## Verification
The bound checker examines every cycle. It checks that each update case moves the counters by exactly one step, that the rotation base wraps from 0 to 47, that a load wins over a branch in the same cycle, that idle cycles and the done case hold all state, and that the rename output stays inside its window. Some properties depend on the exact case boundaries, and only the bench scenarios can demonstrate them. These are the taken or fall-through sense of both branch forms at each boundary (epilog count 2 versus 1, loop count with a zero epilog count), full trips of the base around the window, and the exact physical slot for every logical number. The bench compares all of these against its behavioural model on every clock.

// File: rtl/lcb_pkg.sv
package lcb_pkg;

    typedef enum logic [1:0] {
        PH_DONE   = 2'd0,
        PH_KERNEL = 2'd1,
        PH_DRAIN  = 2'd2,
        PH_LAST   = 2'd3
    } loop_phase_e;

    localparam logic BR_LOOP_TOP  = 1'b0;
    localparam logic BR_LOOP_EXIT = 1'b1;

endpackage

// File: rtl/lcb_counters.sv
module lcb_counters
    import lcb_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_lc,
    input  logic [CNT_W-1:0] ld_ec,
    input  logic             step,
    output logic [CNT_W-1:0] lc,
    output logic [CNT_W-1:0] ec,
    output loop_phase_e      phase,
    output logic             rotate,
    output logic             pred_one,
    output logic             go_on
);

    logic [CNT_W-1:0] lc_q, ec_q, lc_d, ec_d;
    loop_phase_e      phase_q, phase_d;

    // next counter values for the current case
    always_comb begin
        lc_d = lc_q;
        ec_d = ec_q;
        if (ld_en) begin
            lc_d = ld_lc;
            ec_d = ld_ec;
        end else if (step) begin
            unique case (phase_q)
                PH_KERNEL:         lc_d = lc_q - CNT_W'(1);
                PH_DRAIN, PH_LAST: ec_d = ec_q - CNT_W'(1);
                PH_DONE:           ;
            endcase
        end
    end

    // classify the next counts into the next case
    always_comb begin
        if (lc_d != '0)
            phase_d = PH_KERNEL;
        else if (ec_d > CNT_W'(1))
            phase_d = PH_DRAIN;
        else if (ec_d == CNT_W'(1))
            phase_d = PH_LAST;
        else
            phase_d = PH_DONE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= PH_DONE;
        else
            phase_q <= phase_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lc_q <= '0;
            ec_q <= '0;
        end else begin
            lc_q <= lc_d;
            ec_q <= ec_d;
        end
    end

    // outputs of the current case
    always_comb begin
        rotate   = 1'b0;
        pred_one = 1'b0;
        go_on    = 1'b0;
        unique case (phase_q)
            PH_KERNEL: begin
                rotate   = step;
                pred_one = 1'b1;
                go_on    = 1'b1;
            end
            PH_DRAIN: begin
                rotate = step;
                go_on  = 1'b1;
            end
            PH_LAST: begin
                rotate = step;
            end
            PH_DONE: ;
        endcase
    end

    assign lc    = lc_q;
    assign ec    = ec_q;
    assign phase = phase_q;

endmodule

// File: rtl/lcb_rot_base.sv
module lcb_rot_base #(
    parameter int ROT_COUNT = 48,
    parameter int BASE_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec,
    output logic [BASE_W-1:0] base
);

    localparam logic [BASE_W-1:0] TOP = BASE_W'(ROT_COUNT - 1);

    logic [BASE_W-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            base_q <= '0;
        else if (dec)
            base_q <= (base_q == '0) ? TOP : base_q - BASE_W'(1);
    end

    assign base = base_q;

endmodule

// File: rtl/lcb_pred_rename.sv
module lcb_pred_rename #(
    parameter int PRED_NUM  = 64,
    parameter int ROT_FIRST = 16,
    parameter int IDX_W     = 6,
    parameter int BASE_W    = 6
) (
    input  logic [IDX_W-1:0]  log_idx,
    input  logic [BASE_W-1:0] base,
    output logic [IDX_W-1:0]  phys_idx
);

    localparam int ROT_COUNT = PRED_NUM - ROT_FIRST;

    logic [IDX_W-1:0] offs, room, slot;

    always_comb begin
        offs = log_idx - IDX_W'(ROT_FIRST);
        // distance from the base to the end of the window
        room = IDX_W'(ROT_COUNT) - IDX_W'(base);
        if (offs >= room)
            slot = offs - room;
        else
            slot = offs + IDX_W'(base);
        if (log_idx < IDX_W'(ROT_FIRST))
            phys_idx = log_idx;
        else
            phys_idx = slot + IDX_W'(ROT_FIRST);
    end

endmodule

// File: rtl/lcb_loop_branch.sv
module lcb_loop_branch
    import lcb_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int PRED_NUM  = 64,
    parameter int ROT_FIRST = 16,
    parameter int IDX_W     = $clog2(PRED_NUM),
    parameter int BASE_W    = $clog2(PRED_NUM - ROT_FIRST)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_load,
    input  logic [CNT_W-1:0]  load_lc,
    input  logic [CNT_W-1:0]  load_ec,
    input  logic              br_req,
    input  logic              br_kind,
    output logic              br_taken,
    output logic              stage_pred_we,
    output logic              stage_pred_val,
    output logic [CNT_W-1:0]  loop_cnt,
    output logic [CNT_W-1:0]  epi_cnt,
    output logic [BASE_W-1:0] rot_base,
    output logic [1:0]        loop_phase,
    input  logic [IDX_W-1:0]  log_pidx,
    output logic [IDX_W-1:0]  phys_pidx
);

    localparam int ROT_COUNT = PRED_NUM - ROT_FIRST;

    logic        accept;
    logic        rotate, pred_one, go_on;
    loop_phase_e phase;

    // a load in the same cycle wins over the branch
    assign accept = br_req && !cnt_load;

    lcb_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (cnt_load),
        .ld_lc    (load_lc),
        .ld_ec    (load_ec),
        .step     (accept),
        .lc       (loop_cnt),
        .ec       (epi_cnt),
        .phase    (phase),
        .rotate   (rotate),
        .pred_one (pred_one),
        .go_on    (go_on)
    );

    lcb_rot_base #(.ROT_COUNT(ROT_COUNT), .BASE_W(BASE_W)) u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (rotate),
        .base  (rot_base)
    );

    lcb_pred_rename #(
        .PRED_NUM  (PRED_NUM),
        .ROT_FIRST (ROT_FIRST),
        .IDX_W     (IDX_W),
        .BASE_W    (BASE_W)
    ) u_ren (
        .log_idx  (log_pidx),
        .base     (rot_base),
        .phys_idx (phys_pidx)
    );

    always_comb begin
        if (br_kind == BR_LOOP_EXIT)
            br_taken = accept && !go_on;
        else
            br_taken = accept && go_on;
    end

    assign stage_pred_we  = accept;
    assign stage_pred_val = accept && pred_one;
    assign loop_phase     = phase;

endmodule

// File: rtl/lcb_loop_branch_chk.sv
module lcb_loop_branch_chk #(
    parameter int CNT_W     = 32,
    parameter int PRED_NUM  = 64,
    parameter int ROT_FIRST = 16,
    parameter int IDX_W     = 6,
    parameter int BASE_W    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_load,
    input logic [CNT_W-1:0]  load_lc,
    input logic [CNT_W-1:0]  load_ec,
    input logic              br_req,
    input logic              br_kind,
    input logic              br_taken,
    input logic              stage_pred_we,
    input logic              stage_pred_val,
    input logic [CNT_W-1:0]  loop_cnt,
    input logic [CNT_W-1:0]  epi_cnt,
    input logic [BASE_W-1:0] rot_base,
    input logic [1:0]        loop_phase,
    input logic [IDX_W-1:0]  log_pidx,
    input logic [IDX_W-1:0]  phys_pidx
);

    localparam int ROT_COUNT = PRED_NUM - ROT_FIRST;

    logic acc;
    assign acc = br_req && !cnt_load;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> loop_cnt == $past(load_lc) && epi_cnt == $past(load_ec)
                     && rot_base == $past(rot_base)); // R9

    AST_KERNEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        acc && loop_cnt != '0 |=> loop_cnt == $past(loop_cnt) - CNT_W'(1)
                                  && epi_cnt == $past(epi_cnt)); // R2

    AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        acc && loop_cnt == '0 && epi_cnt != '0 |=> loop_cnt == '0
            && epi_cnt == $past(epi_cnt) - CNT_W'(1)); // R3

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        acc && loop_cnt == '0 && epi_cnt == '0 |=> loop_cnt == '0
            && epi_cnt == '0 && $stable(rot_base)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !br_req && !cnt_load |=> $stable(loop_cnt) && $stable(epi_cnt)
                                 && $stable(rot_base)); // R10

    AST_BASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (loop_cnt != '0 || epi_cnt != '0) |=> rot_base ==
            (($past(rot_base) == '0) ? BASE_W'(ROT_COUNT - 1)
                                     : $past(rot_base) - BASE_W'(1))); // R7

    AST_TAKEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> acc && stage_pred_we); // R6

    AST_STAGE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        stage_pred_val |-> stage_pred_we && loop_cnt != '0); // R2

    AST_LAST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        loop_phase == 2'd3 |-> loop_cnt == '0 && epi_cnt == CNT_W'(1)); // R11

    AST_MAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        log_pidx < IDX_W'(ROT_FIRST) |-> phys_pidx == log_pidx); // R8

    AST_MAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        log_pidx >= IDX_W'(ROT_FIRST) |-> phys_pidx >= IDX_W'(ROT_FIRST)); // R8

endmodule

bind lcb_loop_branch lcb_loop_branch_chk #(
    .CNT_W     (CNT_W),
    .PRED_NUM  (PRED_NUM),
    .ROT_FIRST (ROT_FIRST),
    .IDX_W     (IDX_W),
    .BASE_W    (BASE_W)
) u_chk (.*);

// File: tb/lcb_loop_branch_bench.sv
module lcb_loop_branch_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnt_load = 1'b0;
    logic [CNT_W-1:0] load_lc = '0;
    logic [CNT_W-1:0] load_ec = '0;
    logic             br_req = 1'b0;
    logic             br_kind = 1'b0;
    logic             br_taken, stage_pred_we, stage_pred_val;
    logic [CNT_W-1:0] loop_cnt, epi_cnt;
    logic [5:0]       rot_base;
    logic [1:0]       loop_phase;
    logic [5:0]       log_pidx = '0;
    logic [5:0]       phys_pidx;

    int checks = 0;
    int failures = 0;
    int nstep = 0;
    bit finished = 0;

    // behavioural reference state
    longint m_lc = 0, m_ec = 0, m_base = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcb_loop_branch u_lcb_loop_branch (
        .clk(clk), .rst_n(rst_n), .cnt_load(cnt_load), .load_lc(load_lc),
        .load_ec(load_ec), .br_req(br_req), .br_kind(br_kind),
        .br_taken(br_taken), .stage_pred_we(stage_pred_we),
        .stage_pred_val(stage_pred_val), .loop_cnt(loop_cnt),
        .epi_cnt(epi_cnt), .rot_base(rot_base), .loop_phase(loop_phase),
        .log_pidx(log_pidx), .phys_pidx(phys_pidx)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic longint m_phase();
        if (m_lc != 0) return 1;
        if (m_ec > 1) return 2;
        if (m_ec == 1) return 3;
        return 0;
    endfunction

    function automatic longint m_map(input longint li);
        if (li < 16) return li;
        return 16 + ((li - 16 + m_base) % 48);
    endfunction

    task automatic check_regs();
        chk(loop_cnt == CNT_W'(m_lc), "R2/R9 loop count", loop_cnt, m_lc);
        chk(epi_cnt == CNT_W'(m_ec), "R3/R4 epilog count", epi_cnt, m_ec);
        chk(rot_base == 6'(m_base), "R7 rotation base", rot_base, m_base);
        chk(loop_phase == 2'(m_phase()), "R11 phase", loop_phase, m_phase());
    endtask

    task automatic step(input bit ld, input longint lv, input longint ev,
                        input bit req, input bit kind);
        bit acc, cont, exp_t, exp_v;
        longint li;
        @(negedge clk);
        cnt_load = ld; load_lc = CNT_W'(lv); load_ec = CNT_W'(ev);
        br_req = req; br_kind = kind;
        li = (nstep * 7) % 64;
        log_pidx = 6'(li);
        nstep++;
        #1;
        acc = req && !ld;
        cont = (m_lc != 0) || (m_ec > 1);
        exp_t = acc && (kind ? !cont : cont);
        exp_v = acc && (m_lc != 0);
        chk(br_taken == exp_t, kind ? "R6 exit-form taken" : "R6 top-form taken", br_taken, exp_t);
        chk(stage_pred_we == acc, "R9 stage write strobe", stage_pred_we, acc);
        chk(stage_pred_val == exp_v, "R2/R3 stage bit", stage_pred_val, exp_v);
        chk(phys_pidx == 6'(m_map(li)), "R8 rename", phys_pidx, m_map(li));
        @(posedge clk);
        if (ld) begin
            m_lc = lv; m_ec = ev;
        end else if (req) begin
            if (m_lc != 0) begin
                m_lc--; m_base = (m_base + 47) % 48;
            end else if (m_ec != 0) begin
                m_ec--; m_base = (m_base + 47) % 48;
            end
        end
        #1;
        check_regs();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check_regs();
        chk(br_taken == 1'b0, "R1 no taken in reset", br_taken, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R5 done case, both forms
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 1);
        // R9 load with simultaneous branch
        step(1, 3, 2, 1, 0);
        // R2 R3 R4 kernel through drain and last, base wraps (R7)
        for (int i = 0; i < 7; i++) step(0, 0, 0, 1, 0);
        // R10 idle holds
        step(1, 2, 3, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1);
        // exit form across all cases
        for (int i = 0; i < 7; i++) step(0, 0, 0, 1, 1);
        // kernel with zero epilog count
        step(1, 2, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0);
        // long loop: several full trips of the base (R7, R8)
        step(1, 120, 1, 0, 0);
        for (int i = 0; i < 125; i++) step(0, 0, 0, 1, i[0]);
        // mixed stimulus
        for (int i = 0; i < 400; i++) begin
            bit ld = ($urandom_range(0, 9) == 0);
            step(ld, $urandom_range(0, 4), $urandom_range(0, 3),
                 $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule